// File: doc/BRIEF.md
# Directory Home Engine for One Coherent Address

This block is the memory side of a writer-push, directory-based coherence scheme, narrowed to a single address shared by a small fixed number of cache sites. It keeps the memory copy of the address, a sharer set, and, while a writeback is being resolved, two further sets: the sites that still owe an answer to a purge request, and the writebacks that have arrived and are held back together with their data.

Messages from the caches come in on one valid/ready channel. Each carries a kind, a source site and a data value. Replies leave on a second valid/ready channel, tagged with the destination site. The output is a single register, so at most one message leaves per cycle. A message that is presented and not taken holds its kind, site and data unchanged until `out_ready` is high. On the input side `in_ready` is a combinational function of the current phase, the presented `in_kind` and, for a fill request in the stable phase, of `out_ready`. A sender keeps a message presented until it sees `in_ready` high at a clock edge.

A writeback received in the stable phase opens a transient phase. Purge requests go to every other sharer. Once every site owed an answer has sent a Purge or a writeback, memory takes the value of the lowest-numbered held writeback. That site gets a WbAck and keeps a clean copy. Every other held writeback gets a FlushAck, and the engine then returns to the stable phase.

Top module: `home_dir_engine`

## Requirements
- R1: After reset the engine is in the stable phase with `out_valid` low, an empty sharer set, and memory equal to the parameter `MEM_INIT`. In that phase `in_ready` is high for a Purge (`in_kind` 1).
- R2: In the stable phase a fill request (`in_kind` 0) from site s is accepted when the output slot is free or draining. One Cache message (`out_kind` 0) to site s carrying the memory value follows, and s joins the sharer set.
- R3: While `out_valid` is high and `out_ready` is low, `out_kind`, `out_site` and `out_data` stay unchanged in the next cycle and `out_valid` stays high.
- R4: A writeback (`in_kind` 2) from site w in the stable phase sends one purge request (`out_kind` 1, data 0) to every sharer other than w, in ascending site order. No purge request goes to w.
- R5: From the acceptance of a writeback in the stable phase until the last acknowledgement of that transient phase leaves the output, no fill request is accepted.
- R6: In the transient phase a Purge or a writeback from site s removes s from the set of owed answers. A site whose answer is accepted before or in the cycle its purge request would be issued receives no purge request.
- R7: When no answers are owed, memory takes the data of the lowest-numbered held writeback. That site gets a WbAck (`out_kind` 2), and every other held writeback site gets a FlushAck (`out_kind` 3). The acknowledgements leave in ascending site order with data 0.
- R8: A Cache message sent after a transient phase carries the value written at its completion.
- R9: After completion the WbAck site stays a sharer, while FlushAck sites and purged sites leave the set. A Purge accepted in the stable phase removes its source from the sharer set.
- R10: A writeback from the only sharer sends no purge request and completes at once with a single WbAck to the writer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming message present |
| in_ready | output | 1 | Incoming message taken at this edge |
| in_kind | input | 2 | 0 fill request, 1 Purge, 2 writeback, 3 reserved (ignored) |
| in_site | input | SW | Source site of the incoming message |
| in_data | input | DW | Writeback data |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Receiver takes the outgoing message |
| out_kind | output | 2 | 0 Cache, 1 purge request, 2 WbAck, 3 FlushAck |
| out_site | output | SW | Destination site |
| out_data | output | DW | Memory value for Cache, 0 otherwise |

## Verification
The collision that matters is an answer from a site arriving in the same cycle that the purge-request issuer would pick that same site. The bench provokes it by sending a Purge from the lowest-numbered other sharer in the cycle right after the opening writeback is taken, with `out_ready` held high. It judges the result by the number of purge requests that site receives, which must be zero, and by the remaining sites still being served in ascending order. The bench also overlaps held output messages with incoming answers under pseudo-random `out_ready`, and compares every message that leaves with a behavioural reference model.

// File: rtl/hm_pkg.sv
package hm_pkg;
  localparam logic [1:0] KIND_REQ   = 2'd0;
  localparam logic [1:0] KIND_PURGE = 2'd1;
  localparam logic [1:0] KIND_WB    = 2'd2;

  localparam logic [1:0] MSG_CACHE  = 2'd0;
  localparam logic [1:0] MSG_PURREQ = 2'd1;
  localparam logic [1:0] MSG_WBACK  = 2'd2;
  localparam logic [1:0] MSG_FLUSH  = 2'd3;

  typedef enum logic [1:0] {
    PH_STABLE = 2'd0,
    PH_COLLECT = 2'd1,
    PH_ACK = 2'd2
  } phase_e;
endpackage

// File: rtl/hm_pick.sv
module hm_pick #(
  parameter int N  = 4,
  parameter int SW = 2
) (
  input  logic [N-1:0]  mask,
  output logic          found,
  output logic [SW-1:0] idx,
  output logic [N-1:0]  oh
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) idx = SW'(i);
    end
    found = |mask;
    oh = found ? (N'(1) << idx) : '0;
  end
endmodule

// File: rtl/hm_wb_store.sv
module hm_wb_store #(
  parameter int N  = 4,
  parameter int SW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_site,
  input  logic [DW-1:0] wr_data,
  input  logic [SW-1:0] rd_site,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] held [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) held[g] <= '0;
      else if (wr_en && (wr_site == SW'(g))) held[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_site == SW'(i)) rd_data = held[i];
    end
  end
endmodule

// File: rtl/hm_out_reg.sv
module hm_out_reg #(
  parameter int SW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [1:0]    ld_kind,
  input  logic [SW-1:0] ld_site,
  input  logic [DW-1:0] ld_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [1:0]    out_kind,
  output logic [SW-1:0] out_site,
  output logic [DW-1:0] out_data,
  output logic          slot_free
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_site  <= '0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_kind  <= ld_kind;
      out_site  <= ld_site;
      out_data  <= ld_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) &&
                                   $stable(out_site) && $stable(out_data)));
endmodule

// File: rtl/home_dir_engine.sv
module home_dir_engine
  import hm_pkg::*;
#(
  parameter int          NSITES      = 4,
  parameter int          DW          = 8,
  parameter int unsigned MEM_INIT    = 'h5A,
  parameter bit          GRANT_WBACK = 1'b1,
  localparam int         SW          = (NSITES > 1) ? $clog2(NSITES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_kind,
  input  logic [SW-1:0] in_site,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_kind,
  output logic [SW-1:0] out_site,
  output logic [DW-1:0] out_data
);
  phase_e            state_q, state_n;
  logic [NSITES-1:0] sharers_q, sharers_n;
  logic [NSITES-1:0] dir_q, dir_n;
  logic [NSITES-1:0] psend_q, psend_n;
  logic [NSITES-1:0] susp_q, susp_n;
  logic [NSITES-1:0] ackm_q, ackm_n;
  logic [SW-1:0]     grant_q, grant_n;
  logic [DW-1:0]     mem_q, mem_n;

  logic              slot_free, accept, load, wr_en;
  logic [1:0]        ld_kind;
  logic [SW-1:0]     ld_site;
  logic [DW-1:0]     ld_data, rd_data;
  logic [NSITES-1:0] src_oh, resp_mask, psend_eff;

  logic              send_found, susp_found, ack_found;
  logic [SW-1:0]     send_idx, susp_idx, ack_idx;
  logic [NSITES-1:0] send_oh, susp_oh, ack_oh;

  assign src_oh = NSITES'(1) << in_site;

  always_comb begin
    case (state_q)
      PH_STABLE:  in_ready = (in_kind == KIND_REQ) ? slot_free : 1'b1;
      PH_COLLECT: in_ready = (dir_q != '0) && (in_kind != KIND_REQ);
      default:    in_ready = 1'b0;
    endcase
  end

  assign accept = in_valid && in_ready;
  assign resp_mask = (accept && (state_q == PH_COLLECT) &&
                      ((in_kind == KIND_PURGE) || (in_kind == KIND_WB))) ? src_oh : '0;
  assign psend_eff = psend_q & ~resp_mask;

  hm_pick #(.N(NSITES), .SW(SW)) u_pick_send (
    .mask(psend_eff), .found(send_found), .idx(send_idx), .oh(send_oh));
  hm_pick #(.N(NSITES), .SW(SW)) u_pick_susp (
    .mask(susp_q), .found(susp_found), .idx(susp_idx), .oh(susp_oh));
  hm_pick #(.N(NSITES), .SW(SW)) u_pick_ack (
    .mask(ackm_q), .found(ack_found), .idx(ack_idx), .oh(ack_oh));

  hm_wb_store #(.N(NSITES), .SW(SW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_site(in_site),
    .wr_data(in_data), .rd_site(susp_idx), .rd_data(rd_data));

  hm_out_reg #(.SW(SW), .DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_kind(ld_kind),
    .ld_site(ld_site), .ld_data(ld_data), .out_ready(out_ready),
    .out_valid(out_valid), .out_kind(out_kind), .out_site(out_site),
    .out_data(out_data), .slot_free(slot_free));

  always_comb begin
    state_n   = state_q;
    sharers_n = sharers_q;
    dir_n     = dir_q;
    psend_n   = psend_q;
    susp_n    = susp_q;
    ackm_n    = ackm_q;
    grant_n   = grant_q;
    mem_n     = mem_q;
    load      = 1'b0;
    ld_kind   = MSG_CACHE;
    ld_site   = '0;
    ld_data   = '0;
    wr_en     = 1'b0;
    case (state_q)
      PH_STABLE: begin
        if (accept) begin
          case (in_kind)
            KIND_REQ: begin
              load      = 1'b1;
              ld_kind   = MSG_CACHE;
              ld_site   = in_site;
              ld_data   = mem_q;
              sharers_n = sharers_q | src_oh;
            end
            KIND_PURGE: sharers_n = sharers_q & ~src_oh;
            KIND_WB: begin
              state_n = PH_COLLECT;
              dir_n   = sharers_q & ~src_oh;
              psend_n = sharers_q & ~src_oh;
              susp_n  = src_oh;
              wr_en   = 1'b1;
            end
            default: ;
          endcase
        end
      end
      PH_COLLECT: begin
        dir_n   = dir_q & ~resp_mask;
        psend_n = psend_eff;
        if (accept && (in_kind == KIND_PURGE)) sharers_n = sharers_q & ~src_oh;
        if (accept && (in_kind == KIND_WB)) begin
          susp_n = susp_q | src_oh;
          wr_en  = 1'b1;
        end
        if (slot_free && send_found) begin
          load    = 1'b1;
          ld_kind = MSG_PURREQ;
          ld_site = send_idx;
          psend_n = psend_eff & ~send_oh;
        end
        if (dir_q == '0) begin
          state_n   = PH_ACK;
          mem_n     = rd_data;
          ackm_n    = susp_q;
          grant_n   = susp_idx;
          sharers_n = (sharers_q & ~susp_q) | (GRANT_WBACK ? susp_oh : '0);
        end
      end
      default: begin
        if (slot_free && ack_found) begin
          load    = 1'b1;
          ld_kind = (GRANT_WBACK && (ack_idx == grant_q)) ? MSG_WBACK : MSG_FLUSH;
          ld_site = ack_idx;
          ackm_n  = ackm_q & ~ack_oh;
        end
        if ((ackm_q == '0) && slot_free) state_n = PH_STABLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= PH_STABLE;
      sharers_q <= '0;
      dir_q     <= '0;
      psend_q   <= '0;
      susp_q    <= '0;
      ackm_q    <= '0;
      grant_q   <= '0;
      mem_q     <= DW'(MEM_INIT);
    end else begin
      state_q   <= state_n;
      sharers_q <= sharers_n;
      dir_q     <= dir_n;
      psend_q   <= psend_n;
      susp_q    <= susp_n;
      ackm_q    <= ackm_n;
      grant_q   <= grant_n;
      mem_q     <= mem_n;
    end
  end

  assert_no_fill_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PH_STABLE) |-> !(in_valid && in_ready && (in_kind == KIND_REQ)));

  assert_psend_owed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (psend_q & ~dir_q) == '0);

  assert_grant_exists_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_COLLECT) |-> (susp_q != '0));

  assert_wback_site_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_kind == MSG_WBACK)) |-> (out_site == grant_q));

  assert_cache_fresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_kind == MSG_CACHE) && (state_q == PH_STABLE)) |->
      (out_data == mem_q));
endmodule

// File: tb/sim_home_dir_engine.sv
`timescale 1ns/1ps
module sim_home_dir_engine;
  localparam int N = 4;
  localparam int SW = 2;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] in_kind = '0;
  logic [SW-1:0] in_site = '0;
  logic [DW-1:0] in_data = '0;
  logic out_valid, out_ready = 1'b1;
  logic [1:0] out_kind;
  logic [SW-1:0] out_site;
  logic [DW-1:0] out_data;

  always #2.5 clk = ~clk;

  home_dir_engine #(.NSITES(N), .DW(DW), .MEM_INIT('h5A), .GRANT_WBACK(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_site(in_site), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_site(out_site), .out_data(out_data));

  int nchk = 0, nfail = 0, cyc = 0;
  bit rnd_mode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  logic [N-1:0] sh_m = '0, owed_m = '0, pset_m = '0, reqd_m = '0, susp_m = '0;
  int sval_m [N];
  int mem_m = 'h5A, lastreq_m = -1, acks_left = 0, last_cache = -1;
  int preq_cnt [N];
  int last_ack_kind = -1, last_ack_site = -1;
  bit busy_m = 1'b0;
  int qk[$], qs[$], qd[$];
  bit hold_p = 1'b0;
  logic [1:0] hk_p; logic [SW-1:0] hs_p; logic [DW-1:0] hd_p;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_model();
    int g;
    g = -1;
    for (int i = 0; i < N; i++) if (susp_m[i] && g < 0) g = i;
    mem_m = sval_m[g];
    acks_left = 0;
    for (int i = 0; i < N; i++) begin
      if (susp_m[i]) begin
        qk.push_back(i == g ? 2 : 3); qs.push_back(i); qd.push_back(0);
        acks_left++;
      end
    end
    sh_m = (sh_m & ~susp_m) | (N'(1) << g);
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = rnd_mode ? lfsr[0] : 1'b1;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
    if (rst_n) begin
      if (hold_p)
        chk(out_valid && out_kind == hk_p && out_site == hs_p && out_data == hd_p,
            "R3 held message", {out_valid, out_kind, out_site, out_data},
            {1'b1, hk_p, hs_p, hd_p});
      hold_p = out_valid && !out_ready;
      hk_p = out_kind; hs_p = out_site; hd_p = out_data;

      if (out_valid && out_ready) begin
        if (out_kind == 2'd1) begin
          chk(busy_m && pset_m[out_site] && !reqd_m[out_site] &&
              int'(out_site) > lastreq_m && out_data == 0,
              "R4 purge request target", out_site, lastreq_m + 1);
          reqd_m[out_site] = 1'b1;
          lastreq_m = int'(out_site);
          preq_cnt[out_site]++;
        end else if (qk.size() == 0) begin
          chk(1'b0, "R2 unexpected message", out_kind, 0);
        end else begin
          chk(out_kind == qk[0] && out_site == qs[0] && out_data == qd[0],
              (qk[0] == 0) ? "R2 cache reply" : "R7 acknowledgement",
              {out_kind, out_site, out_data}, {qk[0][1:0], qs[0][SW-1:0], qd[0][DW-1:0]});
          if (qk[0] == 0) last_cache = int'(out_data);
          else begin
            last_ack_kind = int'(out_kind); last_ack_site = int'(out_site);
            acks_left--;
            if (acks_left == 0) busy_m = 1'b0;
          end
          void'(qk.pop_front()); void'(qs.pop_front()); void'(qd.pop_front());
        end
      end

      if (in_valid && in_ready) begin
        if (!busy_m) begin
          case (in_kind)
            2'd0: begin
              qk.push_back(0); qs.push_back(int'(in_site)); qd.push_back(mem_m);
              sh_m[in_site] = 1'b1;
            end
            2'd1: sh_m[in_site] = 1'b0;
            2'd2: begin
              busy_m = 1'b1;
              owed_m = sh_m & ~(N'(1) << in_site);
              pset_m = owed_m; reqd_m = '0; lastreq_m = -1;
              for (int i = 0; i < N; i++) preq_cnt[i] = 0;
              susp_m = N'(1) << in_site;
              sval_m[in_site] = int'(in_data);
              if (owed_m == '0) finish_model();
            end
            default: ;
          endcase
        end else begin
          if (in_kind == 2'd0) chk(1'b0, "R5 fill accepted while busy", 1, 0);
          else if (in_kind == 2'd1 || in_kind == 2'd2) begin
            owed_m[in_site] = 1'b0;
            if (in_kind == 2'd1) sh_m[in_site] = 1'b0;
            else begin susp_m[in_site] = 1'b1; sval_m[in_site] = int'(in_data); end
            if (owed_m == '0) finish_model();
          end
        end
      end
    end
  end

  task automatic send(input logic [1:0] k, input int s, input int d);
    in_kind = k; in_site = SW'(s); in_data = DW'(d); in_valid = 1'b1;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do begin @(posedge clk); #1; end
    while (qk.size() != 0 || busy_m || out_valid);
  endtask

  task automatic wait_reqd(input logic [N-1:0] target);
    while (reqd_m != target) begin @(posedge clk); #1; end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin preq_cnt[i] = 0; sval_m[i] = 0; end
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    in_kind = 2'd1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 reset in_ready for Purge", in_ready, 1);
    @(posedge clk); #1;

    // R2 fills from every site, R3 under random back-pressure
    rnd_mode = 1'b1;
    for (int s = 0; s < N; s++) send(2'd0, s, 0);
    wait_idle();
    chk(last_cache == 'h5A, "R1 memory init", last_cache, 'h5A);

    // R4/R5/R7: writeback from site 2
    send(2'd2, 2, 'h11);
    in_kind = 2'd0; in_site = 0; in_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R5 fill stalled", in_ready, 0);
    end
    @(posedge clk); #1 in_valid = 1'b0;
    wait_reqd(4'b1011);
    send(2'd1, 0, 0);
    send(2'd2, 1, 'h22);
    send(2'd1, 3, 0);
    wait_idle();
    chk(preq_cnt[2] == 0, "R4 no purge to writer", preq_cnt[2], 0);
    chk(last_ack_kind == 3 && last_ack_site == 2, "R7 flush to site 2",
        {last_ack_kind, last_ack_site}, {3, 2});

    // R8: fill after completion carries the granted value
    send(2'd0, 3, 0);
    wait_idle();
    chk(last_cache == 'h22, "R8 updated value", last_cache, 'h22);

    // R9/R10: voluntary purge, then writeback from sole sharer
    send(2'd1, 1, 0);
    send(2'd1, 0, 0);
    send(2'd2, 3, 'h33);
    wait_idle();
    chk(preq_cnt[1] == 0 && preq_cnt[0] == 0, "R9 dropped sites not purged",
        preq_cnt[1] + preq_cnt[0], 0);
    chk(last_ack_kind == 2 && last_ack_site == 3, "R10 lone WbAck",
        {last_ack_kind, last_ack_site}, {2, 3});

    // R6 collision: answer from site 1 right after the opening writeback
    rnd_mode = 1'b0;
    for (int s = 0; s < 3; s++) send(2'd0, s, 0);
    wait_idle();
    chk(last_cache == 'h33, "R8 value after lone writeback", last_cache, 'h33);
    send(2'd2, 0, 'h44);
    send(2'd1, 1, 0);
    wait_reqd(4'b1100);
    send(2'd2, 2, 'h55);
    send(2'd2, 3, 'h66);
    wait_idle();
    chk(preq_cnt[1] == 0, "R6 cancelled purge request", preq_cnt[1], 0);
    send(2'd0, 2, 0);
    wait_idle();
    chk(last_cache == 'h44, "R7 lowest writeback wins", last_cache, 'h44);
    chk(qk.size() == 0, "R2 queue drained", qk.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule